// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Encoded Invalidation

This block is the translation lookaside store of an I/O memory management unit. It holds a small, fully associative set of page translations. Each line is tagged with a 7-bit address-space identifier (ASID) and the 20-bit virtual page number VA[31:12] of a 4 KiB page. Each line holds a 20-bit physical frame number and three permission flags: read, write and non-secure. A device-side requester presents an ASID and a 32-bit virtual address. One cycle later the block returns hit or miss, the physical address and the permissions. An external table walker installs translations through a fill port.

Invalidation goes through one 32-bit command word. The command selects a match scope: every line, one 4 MiB section or one 16 KiB group. It can also restrict the match to a single ASID. A configuration word sets how many lines are open for allocation. The same word chooses between fixed-victim replacement and rotating (round-robin) replacement.

Top module: `iotlb_flush_cache`

## Requirements
- R1: Reset clears every valid flag. After reset, every lookup misses, and the result-valid output is low until a lookup is requested.
- R2: A lookup asserted in cycle N is answered in cycle N+1. On a hit, the physical address is {frame, VA[11:0]} and the permissions are those of the matching line. On a miss, the address and permissions are zero.
- R3: A fill whose ASID and page number equal those of a valid line overwrites that line. No second line is allocated.
- R4: A command with bits [1:0]=0 and bit 31=0 invalidates every line.
- R5: When command bit 31 is 1, only lines whose ASID equals command bits [30:24] can be invalidated. Lines of other ASIDs are untouched.
- R6: Mode 2 (bits [1:0]=2) invalidates the lines whose VA[31:22] equals command bits [19:10].
- R7: Mode 3 (bits [1:0]=3) invalidates the lines whose VA[31:14] equals command bits [19:2].
- R8: When bit 31 is 0, a section or group match applies to lines of every ASID.
- R9: Mode 1 is reserved. A command in that mode invalidates nothing.
- R10: An invalidation takes effect at the clock edge that accepts the command. A lookup requested in that same cycle still sees the state before the invalidation.
- R11: Configuration bits [3:0] (default 8 lines) give the number of lines open to allocation. Values above the line count are clamped. A fill takes the lowest free open line. With no free open line and rotation off, it replaces line 0. With a count of 0, fills are dropped. The count is 8 after reset.
- R12: Configuration bit 28 enables rotation. When no open line is free, victims are taken in turn from line 0 up to count-1 and then wrap.
- R13: A lookup hits only when both the ASID and the page number match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup ASID |
| lk_va | input | 32 | Lookup virtual address |
| fill_en | input | 1 | Install a translation |
| fill_asid | input | 7 | ASID of the fill |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_pfn | input | 20 | Physical frame number of the fill |
| fill_rd | input | 1 | Read permission of the fill |
| fill_wr | input | 1 | Write permission of the fill |
| fill_ns | input | 1 | Non-secure flag of the fill |
| inv_we | input | 1 | Invalidation command strobe |
| inv_cmd | input | 32 | Invalidation command word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 32 | Configuration word |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit |
| res_pa | output | 32 | Translated physical address |
| res_rd | output | 1 | Read permission of the hit |
| res_wr | output | 1 | Write permission of the hit |
| res_ns | output | 1 | Non-secure flag of the hit |

## Verification
Each lookup is answered exactly one cycle after its request. A fill, an invalidation or a configuration write is visible to a lookup requested in the following cycle. The driver queues one expected result per lookup request. The monitor compares the queued result on the first falling edge after the clock edge that captures the request. The monitor checks every cycle that a result exists exactly when a request was made. The case where an invalidation and a lookup share one cycle is driven on purpose. There the pre-invalidation answer is expected, and the post-invalidation answer is expected on the next lookup.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
    localparam int ASID_W = 7;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 20;
    localparam int OFF_W  = 12;
    localparam int CMD_W  = 32;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic              rd;
        logic              wr;
        logic              ns;
    } tlb_line_t;

    typedef enum logic [1:0] {
        INV_ALL     = 2'd0,
        INV_RSVD    = 2'd1,
        INV_SECTION = 2'd2,
        INV_GROUP   = 2'd3
    } inv_mode_e;

    // Decide whether one stored line falls inside an invalidation command.
    function automatic logic inv_hits(logic [CMD_W-1:0] cmd, tlb_line_t ln);
        logic asid_ok;
        logic area_ok;
        asid_ok = !cmd[31] || (cmd[30:24] == ln.asid);
        case (inv_mode_e'(cmd[1:0]))
            INV_ALL:     area_ok = 1'b1;
            INV_SECTION: area_ok = (ln.vpn[19:10] == cmd[19:10]);
            INV_GROUP:   area_ok = (ln.vpn[19:2] == cmd[19:2]);
            default:     area_ok = 1'b0;
        endcase
        return asid_ok && area_ok;
    endfunction
endpackage

// File: rtl/iotlb_line.sv
module iotlb_line
    import iotlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inv_en,
    input  logic [CMD_W-1:0] inv_cmd,
    input  logic             wr_en,
    input  tlb_line_t        wr_data,
    output logic             valid_o,
    output tlb_line_t        line_o
);
    logic      valid_q;
    tlb_line_t line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            if (inv_en && inv_hits(inv_cmd, line_q))
                valid_q <= 1'b0;
            if (wr_en) begin
                valid_q <= 1'b1;
                line_q  <= wr_data;
            end
        end
    end

    assign valid_o = valid_q;
    assign line_o  = line_q;
endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
    parameter int LINES = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CNT_W = $clog2(LINES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] valid_i,
    input  logic [CNT_W-1:0] active_i,
    input  logic             rr_i,
    input  logic             alloc_i,
    output logic [IDX_W-1:0] slot_o,
    output logic             slot_ok_o
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;
    logic [IDX_W-1:0] rr_slot;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!free_found && !valid_i[i] && (CNT_W'(i) < active_i)) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        rr_slot   = (CNT_W'(ptr_q) < active_i) ? ptr_q : '0;
        slot_ok_o = (active_i != '0);
        if (free_found)
            slot_o = free_idx;
        else if (rr_i)
            slot_o = rr_slot;
        else
            slot_o = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (alloc_i && slot_ok_o && !free_found && rr_i)
            ptr_q <= ((CNT_W'(rr_slot) + CNT_W'(1)) >= active_i) ? '0 : rr_slot + IDX_W'(1);
    end

    // R11
    victim_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_i && slot_ok_o) |-> (CNT_W'(slot_o) < active_i));
endmodule

// File: rtl/iotlb_flush_cache.sv
module iotlb_flush_cache
    import iotlb_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CNT_W = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [31:0]       lk_va,
    input  logic              fill_en,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_rd,
    input  logic              fill_wr,
    input  logic              fill_ns,
    input  logic              inv_we,
    input  logic [CMD_W-1:0]  inv_cmd,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_data,
    output logic              res_valid,
    output logic              res_hit,
    output logic [31:0]       res_pa,
    output logic              res_rd,
    output logic              res_wr,
    output logic              res_ns
);
    logic [CNT_W-1:0] active_q;
    logic             rr_q;
    logic [CNT_W-1:0] cfg_cnt;

    assign cfg_cnt = cfg_data[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= CNT_W'(LINES);
            rr_q     <= 1'b0;
        end else if (cfg_we) begin
            active_q <= (cfg_cnt > CNT_W'(LINES)) ? CNT_W'(LINES) : cfg_cnt;
            rr_q     <= cfg_data[28];
        end
    end

    logic [LINES-1:0] valid_vec;
    tlb_line_t        lines [LINES];
    logic [LINES-1:0] lk_match;
    logic [LINES-1:0] fill_match;
    logic [LINES-1:0] wr_sel;
    tlb_line_t        fill_line;
    logic             dup;
    logic [IDX_W-1:0] slot;
    logic             slot_ok;

    assign fill_line = '{asid: fill_asid, vpn: fill_vpn, pfn: fill_pfn,
                         rd: fill_rd, wr: fill_wr, ns: fill_ns};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        iotlb_line u_line (
            .clk     (clk),
            .rst     (rst),
            .inv_en  (inv_we),
            .inv_cmd (inv_cmd),
            .wr_en   (fill_en && wr_sel[g]),
            .wr_data (fill_line),
            .valid_o (valid_vec[g]),
            .line_o  (lines[g])
        );
        assign lk_match[g]   = valid_vec[g] && (lines[g].asid == lk_asid)
                               && (lines[g].vpn == lk_va[31:OFF_W]);
        assign fill_match[g] = valid_vec[g] && (lines[g].asid == fill_asid)
                               && (lines[g].vpn == fill_vpn);
    end

    assign dup = |fill_match;

    iotlb_victim #(.LINES(LINES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (valid_vec),
        .active_i  (active_q),
        .rr_i      (rr_q),
        .alloc_i   (fill_en && !dup),
        .slot_o    (slot),
        .slot_ok_o (slot_ok)
    );

    always_comb begin
        wr_sel = '0;
        if (dup)
            wr_sel = fill_match;
        else if (slot_ok)
            wr_sel[slot] = 1'b1;
    end

    tlb_line_t hit_line;
    always_comb begin
        hit_line = '0;
        for (int i = 0; i < LINES; i++)
            if (lk_match[i]) hit_line = hit_line | lines[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_pa    <= '0;
            res_rd    <= 1'b0;
            res_wr    <= 1'b0;
            res_ns    <= 1'b0;
        end else begin
            res_valid <= lk_req;
            res_hit   <= lk_req && (|lk_match);
            res_pa    <= (lk_req && |lk_match) ? {hit_line.pfn, lk_va[OFF_W-1:0]} : '0;
            res_rd    <= lk_req && hit_line.rd;
            res_wr    <= lk_req && hit_line.wr;
            res_ns    <= lk_req && hit_line.ns;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (valid_vec == '0));
    // R4
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_we && !inv_cmd[31] && inv_cmd[1:0] == 2'd0 && !fill_en) |=> (valid_vec == '0));
    // R3
    no_dup_tag_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(fill_match));
    // R2
    result_timing_chk: assert property (@(posedge clk) disable iff (rst) lk_req |=> res_valid);
    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_pa == '0 && !res_rd && !res_wr && !res_ns));
endmodule

// File: tb/tb_iotlb_flush_cache.sv
`timescale 1ns/1ps
module tb_iotlb_flush_cache;
    logic        clk = 0, rst = 1;
    logic        lk_req = 0;
    logic [6:0]  lk_asid = 0;
    logic [31:0] lk_va = 0;
    logic        fill_en = 0, fill_rd = 0, fill_wr = 0, fill_ns = 0;
    logic [6:0]  fill_asid = 0;
    logic [19:0] fill_vpn = 0, fill_pfn = 0;
    logic        inv_we = 0, cfg_we = 0;
    logic [31:0] inv_cmd = 0, cfg_data = 0;
    logic        res_valid, res_hit, res_rd, res_wr, res_ns;
    logic [31:0] res_pa;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    iotlb_flush_cache dut (.*);

    typedef struct {
        logic        hit;
        logic [31:0] pa;
        logic [2:0]  perm;
        string       tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    // monitor: one queued expectation per result, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected result actual=valid expected=none");
            end else begin
                e = q.pop_front();
                if (res_hit !== e.hit || res_pa !== e.pa || {res_rd, res_wr, res_ns} !== e.perm) begin
                    failures++;
                    $display("FAIL %s actual=hit%0b pa=%h perm=%b expected=hit%0b pa=%h perm=%b",
                             e.tag, res_hit, res_pa, {res_rd, res_wr, res_ns}, e.hit, e.pa, e.perm);
                end
            end
        end
    end

    task automatic look(input logic [6:0] a, input logic [31:0] va, input logic h,
                        input logic [31:0] pa, input logic [2:0] perm, input string tag);
        exp_t x;
        x.hit = h; x.pa = pa; x.perm = perm; x.tag = tag;
        q.push_back(x);
        lk_req = 1; lk_asid = a; lk_va = va;
        @(negedge clk);
        lk_req = 0;
    endtask

    task automatic fill(input logic [6:0] a, input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [2:0] perm);
        fill_en = 1; fill_asid = a; fill_vpn = vpn; fill_pfn = pfn;
        {fill_rd, fill_wr, fill_ns} = perm;
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic inv(input logic [31:0] cmd);
        inv_we = 1; inv_cmd = cmd;
        @(negedge clk);
        inv_we = 0;
    endtask

    task automatic cfg(input logic [31:0] d);
        cfg_we = 1; cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 idle result actual=%b expected=0", res_valid);
        end
        look(7'd1, 32'h0000_1000, 0, 0, 0, "R1 miss after reset");

        fill(7'd1, 20'h12345, 20'hABCDE, 3'b110);
        look(7'd1, 32'h1234_5678, 1, 32'hABCD_E678, 3'b110, "R2 hit");
        look(7'd2, 32'h1234_5678, 0, 0, 0, "R13 other asid");
        fill(7'd1, 20'h12345, 20'h11111, 3'b101);
        look(7'd1, 32'h1234_5678, 1, 32'h1111_1678, 3'b101, "R3 overwrite");
        inv(32'h0);
        look(7'd1, 32'h1234_5678, 0, 0, 0, "R4 flush all");

        fill(7'd3, 20'h00010, 20'h00A00, 3'b100);
        fill(7'd4, 20'h00010, 20'h00B00, 3'b010);
        inv(32'h8000_0000 | (32'd3 << 24));
        look(7'd3, 32'h0001_0000, 0, 0, 0, "R5 qualified asid gone");
        look(7'd4, 32'h0001_0004, 1, 32'h00B0_0004, 3'b010, "R5 other asid kept");

        inv(32'h0);
        fill(7'd5, 20'h40000, 20'h00001, 3'b111);
        fill(7'd5, 20'h403FF, 20'h00002, 3'b111);
        fill(7'd5, 20'h40400, 20'h00003, 3'b111);
        inv(32'h8000_0000 | (32'd5 << 24) | (32'h100 << 10) | 32'd2);
        look(7'd5, 32'h4000_0000, 0, 0, 0, "R6 section low");
        look(7'd5, 32'h403F_F000, 0, 0, 0, "R6 section high");
        look(7'd5, 32'h4040_0010, 1, 32'h0000_3010, 3'b111, "R6 next section kept");

        inv(32'h0);
        fill(7'd6, 20'h80004, 20'h00004, 3'b001);
        fill(7'd6, 20'h80007, 20'h00005, 3'b001);
        fill(7'd6, 20'h80008, 20'h00006, 3'b001);
        inv(32'h8000_0000 | (32'd6 << 24) | (32'h20001 << 2) | 32'd3);
        look(7'd6, 32'h8000_4000, 0, 0, 0, "R7 group first");
        look(7'd6, 32'h8000_7000, 0, 0, 0, "R7 group last");
        look(7'd6, 32'h8000_8000, 1, 32'h0000_6000, 3'b001, "R7 next group kept");

        inv(32'h0);
        fill(7'd7, 20'h40000, 20'h00007, 3'b100);
        fill(7'd8, 20'h40001, 20'h00008, 3'b100);
        fill(7'd8, 20'h00001, 20'h00009, 3'b100);
        inv((32'h100 << 10) | 32'd2);
        look(7'd7, 32'h4000_0000, 0, 0, 0, "R8 asid7 section");
        look(7'd8, 32'h4000_1000, 0, 0, 0, "R8 asid8 section");
        look(7'd8, 32'h0000_1000, 1, 32'h0000_9000, 3'b100, "R8 outside kept");
        inv(32'h0000_0001);
        look(7'd8, 32'h0000_1000, 1, 32'h0000_9000, 3'b100, "R9 reserved mode");

        fill(7'd9, 20'h00020, 20'h00022, 3'b110);
        inv_we = 1; inv_cmd = 32'h0;
        look(7'd9, 32'h0002_0000, 1, 32'h0002_2000, 3'b110, "R10 same cycle pre-flush");
        inv_we = 0;
        look(7'd9, 32'h0002_0000, 0, 0, 0, "R10 after flush");

        cfg(32'd2);
        inv(32'h0);
        fill(7'd1, 20'h00100, 20'h00100, 3'b100);
        fill(7'd1, 20'h00100, 20'h00101, 3'b100);
        fill(7'd1, 20'h00200, 20'h00200, 3'b100);
        look(7'd1, 32'h0010_0000, 1, 32'h0010_1000, 3'b100, "R3 dup kept one line");
        look(7'd1, 32'h0020_0000, 1, 32'h0020_0000, 3'b100, "R11 second line");
        fill(7'd1, 20'h00300, 20'h00300, 3'b100);
        look(7'd1, 32'h0010_0000, 0, 0, 0, "R11 line0 replaced");
        look(7'd1, 32'h0020_0000, 1, 32'h0020_0000, 3'b100, "R11 line1 kept");
        look(7'd1, 32'h0030_0000, 1, 32'h0030_0000, 3'b100, "R11 new in line0");
        cfg(32'd0);
        fill(7'd1, 20'h00400, 20'h00400, 3'b100);
        look(7'd1, 32'h0040_0000, 0, 0, 0, "R11 zero count drops fill");

        cfg(32'h1000_0002);
        inv(32'h0);
        fill(7'd2, 20'h00A00, 20'h00A00, 3'b010);
        fill(7'd2, 20'h00B00, 20'h00B00, 3'b010);
        fill(7'd2, 20'h00C00, 20'h00C00, 3'b010);
        fill(7'd2, 20'h00D00, 20'h00D00, 3'b010);
        look(7'd2, 32'h00A0_0000, 0, 0, 0, "R12 first victim");
        look(7'd2, 32'h00B0_0000, 0, 0, 0, "R12 second victim");
        look(7'd2, 32'h00C0_0000, 1, 32'h00C0_0000, 3'b010, "R12 kept C");
        look(7'd2, 32'h00D0_0000, 1, 32'h00D0_0000, 3'b010, "R12 kept D");

        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R2 missing results actual=%0d expected=0", q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule